// File: doc/BRIEF.md
# Streaming Pair-Product Authenticator over GF(2^256)

This block computes a 256-bit authentication tag over a byte stream. Incoming bytes are padded and packed into 256-bit field elements. Each element is XORed with a key element that arrives on a separate handshake port. Consecutive elements are paired, and the two sums of a pair are multiplied in GF(2^256). The products of all pairs are XOR-accumulated into a hash. Because each multiplication covers two elements, the block needs half a multiplication per element.

When the message is complete, the block takes a one-time pad word on a third port. It XORs that word into the hash and presents the result as the tag, which is held until it is accepted. The multiplier is bit-serial, one multiplier bit per clock with shift-and-reduce, so one pair costs about 256 cycles. While the multiplier runs, the block accepts no new bytes. The key source must supply key element k for message element k, restarting at element 0 for every message. The same key stream can therefore serve messages of any length.

Top module: `pdp_mac`

## Requirements
- R1: After reset `tag_valid`, `key_ready` and `pad_ready` are 0 and `msg_ready` is 1.
- R2: Byte j of an element (0-based within its 32-byte group) occupies bits 8j+7..8j of the element, and bit i of a byte is the coefficient of x^i.
- R3: After the byte flagged last, the block appends one byte 0x01 and then 0x00 bytes until the padded length is a multiple of 64. A message whose length is already a multiple of 64 therefore grows by a full 64 bytes.
- R4: Every padded element is XORed with exactly one key word, taken by one `key_valid`/`key_ready` handshake, and key words are applied in arrival order.
- R5: Elements 2p and 2p+1 (each already summed with its key word) are multiplied modulo x^256+x^10+x^5+x^2+1, and the hash is the XOR of all such products.
- R6: The tag equals the hash XOR the word taken by the single `pad_valid`/`pad_ready` handshake of that message. This handshake occurs after the last product has been accumulated.
- R7: Once `tag_valid` rises, it and `tag` stay unchanged until `tag_ready` is seen, and `msg_ready` stays 0 while a tag is pending.
- R8: The hash starts from zero for every message, so a tag depends only on its own message, keys and pad word.
- R9: `msg_ready` is 0 while the multiplier is busy or while a complete element waits for its key word. At most one of `msg_ready`, `key_ready`, `pad_ready` and `tag_valid` is high in any cycle.
- R10: The number of key handshakes in a message equals the padded length divided by 32, which is even and nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Message byte present |
| msg_ready | output | 1 | Block accepts a message byte |
| msg_byte | input | 8 | Message byte |
| msg_last | input | 1 | Byte is the final byte of the message |
| key_valid | input | 1 | Key element present |
| key_ready | output | 1 | Block takes a key element |
| key_word | input | 256 | Key element for the current message element |
| pad_valid | input | 1 | One-time pad word present |
| pad_ready | output | 1 | Block takes the pad word |
| pad_word | input | 256 | Per-message pad word |
| tag_valid | output | 1 | Tag present |
| tag_ready | input | 1 | Tag accepted |
| tag | output | 256 | Authentication tag |

## Verification
The bench sends messages whose lengths fall on and around the 32- and 64-byte boundaries (1, 31, 32, 63, 64, 65 and longer). A padder that skipped the 0x01 byte, or that added no extra block at an exact multiple of 64, would produce the wrong number of key handshakes and a wrong tag. Later messages run with random stalls on all three input ports and on tag acceptance. A design that dropped or reused a key word during a stall, that kept the previous hash, or that reordered bytes inside an element would produce tags that differ from the bench's independent LSB-first field model. The bench also watches the pending tag on every cycle, so a tag that changed or vanished before acceptance, or a byte taken while a tag waits, is reported.

// File: rtl/pdp_mac_pkg.sv
package pdp_mac_pkg;

    typedef enum logic [1:0] {
        PH_FILL = 2'd0,
        PH_MUL  = 2'd1,
        PH_PADW = 2'd2,
        PH_TAG  = 2'd3
    } phase_e;

endpackage

// File: rtl/pdp_elem_former.sv
// Packs bytes into field elements and inserts the trailing padding.
module pdp_elem_former #(
    parameter int W = 256
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         in_valid,
    input  logic [7:0]   in_byte,
    input  logic         in_last,
    input  logic         take,
    output logic         in_ready,
    output logic         elem_valid,
    output logic [W-1:0] elem,
    output logic         elem_second,
    output logic         elem_final
);
    localparam int EB = W / 8;
    localparam int IW = $clog2(EB);

    typedef struct packed {
        logic [W-1:0] shreg;
        logic [IW:0]  pos;
        logic         full;
        logic         second;
        logic         fin;
        logic         pad_on;
        logic         one_due;
    } st_t;

    st_t q, d;
    logic       step;
    logic [7:0] byte_v;

    always_comb begin
        d      = q;
        step   = en && !q.full && (q.pad_on || in_valid);
        byte_v = q.pad_on ? {7'd0, q.one_due} : in_byte;
        if (take && q.full) begin
            d.full = 1'b0;
            if (q.fin) begin
                d.pad_on = 1'b0;
            end
        end
        if (step) begin
            d.shreg[{q.pos[IW-1:0], 3'b000} +: 8] = byte_v;
            d.pos = q.pos + 1'b1;
            if (q.pad_on) begin
                d.one_due = 1'b0;
            end else if (in_last) begin
                d.pad_on  = 1'b1;
                d.one_due = 1'b1;
            end
            if (&q.pos[IW-1:0]) begin
                d.full   = 1'b1;
                d.second = q.pos[IW];
                d.fin    = q.pos[IW] & q.pad_on;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign in_ready    = en && !q.full && !q.pad_on;
    assign elem_valid  = q.full;
    assign elem        = q.shreg;
    assign elem_second = q.second;
    assign elem_final  = q.fin;

endmodule

// File: rtl/pdp_gf_mul.sv
// Bit-serial GF(2^W) multiplier, multiplier operand scanned from the top bit.
module pdp_gf_mul #(
    parameter int           W    = 256,
    parameter logic [W-1:0] POLY = 'h425
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] prod
);
    localparam int CW = $clog2(W);

    typedef struct packed {
        logic [W-1:0]  a_r;
        logic [W-1:0]  b_r;
        logic [W-1:0]  acc;
        logic [CW-1:0] cnt;
        logic          busy;
        logic          done;
    } st_t;

    st_t q, d;
    logic [W-1:0] nxt;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        nxt    = {q.acc[W-2:0], 1'b0} ^ (q.acc[W-1] ? POLY : '0);
        if (q.b_r[W-1]) begin
            nxt = nxt ^ q.a_r;
        end
        if (start && !q.busy) begin
            d.a_r  = a;
            d.b_r  = b;
            d.acc  = '0;
            d.cnt  = '0;
            d.busy = 1'b1;
        end else if (q.busy) begin
            d.acc = nxt;
            d.b_r = {q.b_r[W-2:0], 1'b0};
            d.cnt = q.cnt + 1'b1;
            if (q.cnt == CW'(W - 1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy = q.busy;
    assign done = q.done;
    assign prod = q.acc;

endmodule

// File: rtl/pdp_mac.sv
module pdp_mac
    import pdp_mac_pkg::*;
#(
    parameter int           W    = 256,
    parameter logic [W-1:0] POLY = 'h425
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         msg_valid,
    output logic         msg_ready,
    input  logic [7:0]   msg_byte,
    input  logic         msg_last,
    input  logic         key_valid,
    output logic         key_ready,
    input  logic [W-1:0] key_word,
    input  logic         pad_valid,
    output logic         pad_ready,
    input  logic [W-1:0] pad_word,
    output logic         tag_valid,
    input  logic         tag_ready,
    output logic [W-1:0] tag
);
    typedef struct packed {
        phase_e       phase;
        logic [W-1:0] opa;
        logic [W-1:0] acc;
        logic [W-1:0] tag;
        logic         fin;
    } st_t;

    st_t q, d;

    logic         elem_valid, elem_second, elem_final;
    logic [W-1:0] elem, sum, prod;
    logic         take, mul_start, mul_busy, mul_done;

    pdp_elem_former #(.W(W)) u_former (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (q.phase == PH_FILL),
        .in_valid   (msg_valid),
        .in_byte    (msg_byte),
        .in_last    (msg_last),
        .take       (take),
        .in_ready   (msg_ready),
        .elem_valid (elem_valid),
        .elem       (elem),
        .elem_second(elem_second),
        .elem_final (elem_final)
    );

    assign key_ready = (q.phase == PH_FILL) && elem_valid && !mul_busy;
    assign take      = key_valid && key_ready;
    assign sum       = elem ^ key_word;
    assign mul_start = take && elem_second;

    pdp_gf_mul #(.W(W), .POLY(POLY)) u_mul (
        .clk  (clk),
        .rst_n(rst_n),
        .start(mul_start),
        .a    (q.opa),
        .b    (sum),
        .busy (mul_busy),
        .done (mul_done),
        .prod (prod)
    );

    always_comb begin
        d = q;
        case (q.phase)
            PH_FILL: begin
                if (take) begin
                    if (!elem_second) begin
                        d.opa = sum;
                    end else begin
                        d.phase = PH_MUL;
                        d.fin   = elem_final;
                    end
                end
            end
            PH_MUL: begin
                if (mul_done) begin
                    d.acc   = q.acc ^ prod;
                    d.phase = q.fin ? PH_PADW : PH_FILL;
                end
            end
            PH_PADW: begin
                if (pad_valid) begin
                    d.tag   = q.acc ^ pad_word;
                    d.acc   = '0;
                    d.phase = PH_TAG;
                end
            end
            default: begin
                if (tag_ready) begin
                    d.phase = PH_FILL;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign pad_ready = (q.phase == PH_PADW);
    assign tag_valid = (q.phase == PH_TAG);
    assign tag       = q.tag;

endmodule

// File: rtl/pdp_mac_chk.sv
module pdp_mac_chk #(
    parameter int W = 256
) (
    input logic         clk,
    input logic         rst_n,
    input logic         msg_ready,
    input logic         key_valid,
    input logic         key_ready,
    input logic         pad_valid,
    input logic         pad_ready,
    input logic         tag_valid,
    input logic         tag_ready,
    input logic [W-1:0] tag,
    input logic         mul_busy
);
    int unsigned kcnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kcnt_q <= 0;
        end else if (tag_valid && tag_ready) begin
            kcnt_q <= 0;
        end else if (key_valid && key_ready) begin
            kcnt_q <= kcnt_q + 1;
        end
    end

    p_tag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tag_valid && !tag_ready |=> tag_valid && $stable(tag));

    p_no_byte_with_tag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tag_valid |-> !msg_ready);

    p_single_port_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({msg_ready, key_ready, pad_ready, tag_valid}));

    p_busy_blocks_bytes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mul_busy |-> !msg_ready && !key_ready);

    p_even_keys_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pad_valid && pad_ready |-> kcnt_q[0] == 1'b0 && kcnt_q != 0);

endmodule

bind pdp_mac pdp_mac_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .msg_ready(msg_ready),
    .key_valid(key_valid),
    .key_ready(key_ready),
    .pad_valid(pad_valid),
    .pad_ready(pad_ready),
    .tag_valid(tag_valid),
    .tag_ready(tag_ready),
    .tag      (tag),
    .mul_busy (mul_busy)
);

// File: tb/tb_pdp_mac.sv
module tb_pdp_mac;
    localparam int W = 256;
    localparam int LIMIT = 150000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         msg_valid = 1'b0, msg_last = 1'b0;
    logic [7:0]   msg_byte = '0;
    logic         key_valid = 1'b0, pad_valid = 1'b0, tag_ready = 1'b0;
    logic [W-1:0] key_word = '0, pad_word = '0;
    logic         msg_ready, key_ready, pad_ready, tag_valid;
    logic [W-1:0] tag;

    always #4 clk = ~clk;

    pdp_mac dut (
        .clk(clk), .rst_n(rst_n),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_byte(msg_byte), .msg_last(msg_last),
        .key_valid(key_valid), .key_ready(key_ready), .key_word(key_word),
        .pad_valid(pad_valid), .pad_ready(pad_ready), .pad_word(pad_word),
        .tag_valid(tag_valid), .tag_ready(tag_ready), .tag(tag)
    );

    int nchk = 0, nfail = 0, cyc = 0, done_cnt = 0, fin_idx = 0, kidx = 0, tag_idx = 0;
    bit run = 1'b0, stress = 1'b0;
    logic [7:0]   bq[$];
    bit           lq[$];
    logic [7:0]   cur[$];
    logic [W-1:0] exp_tag[$];
    int           exp_nel[$];
    bit           prev_hold = 1'b0;
    logic [W-1:0] prev_tag = '0;

    function automatic logic [W-1:0] key_of(int k);
        logic [W-1:0] r;
        for (int j = 0; j < 8; j++)
            r[32*j +: 32] = (32'(k) + 32'd1) * 32'h9E3779B1 ^ (32'(j) * 32'h7F4A7C15) ^ 32'hA5A50F0F;
        return r;
    endfunction

    function automatic logic [W-1:0] pad_of(int n);
        logic [W-1:0] r;
        for (int j = 0; j < 8; j++)
            r[32*j +: 32] = (32'(n) + 32'd3) * 32'h85EBCA6B ^ (32'(j) * 32'hC2B2AE35) ^ 32'h0F1E2D3C;
        return r;
    endfunction

    // Reference field product: LSB-first scan, modulus x^256+x^10+x^5+x^2+1 (R5)
    function automatic logic [W-1:0] gmul(logic [W-1:0] a, logic [W-1:0] b);
        logic [W-1:0] r = '0;
        logic [W-1:0] x = a;
        for (int i = 0; i < W; i++) begin
            if (b[i]) r = r ^ x;
            x = x[W-1] ? ((x << 1) ^ 256'h425) : (x << 1);
        end
        return r;
    endfunction

    // Pads the collected message and computes its expected tag (R2, R3, R4, R5, R6, R8)
    task automatic finish_message();
        logic [7:0]   p[$];
        logic [W-1:0] e0, e1, h;
        int           nel;
        p = cur;
        p.push_back(8'h01);
        while (p.size() % 64 != 0) p.push_back(8'h00);
        nel = p.size() / 32;
        h = '0;
        e0 = '0;
        for (int e = 0; e < nel; e++) begin
            logic [W-1:0] el;
            for (int j = 0; j < 32; j++) el[8*j +: 8] = p[32*e + j];
            el = el ^ key_of(e);
            if (e % 2 == 0) e0 = el;
            else begin
                e1 = el;
                h = h ^ gmul(e0, e1);
            end
        end
        exp_tag.push_back(h ^ pad_of(fin_idx));
        exp_nel.push_back(nel);
        fin_idx++;
        cur.delete();
    endtask

    task automatic load_msg(int len, int seed);
        for (int i = 0; i < len; i++) begin
            bq.push_back(8'((seed * 37 + i * 11 + (i >> 3)) ^ 8'h5A));
            lq.push_back(i == len - 1);
        end
    endtask

    function automatic bit go();
        return !stress || ($urandom_range(3) != 0);
    endfunction

    always @(negedge clk) begin
        if (rst_n && run) begin
            cyc++;
            if (tag_valid) begin
                nchk++;
                if (exp_tag.size() == 0 || tag !== exp_tag[0]) begin
                    nfail++;
                    $display("FAIL R5 R6 tag of message %0d (R2 R3 R4 R8): got %h expected %h",
                             tag_idx, tag, (exp_tag.size() != 0) ? exp_tag[0] : '0);
                end
                nchk++;
                if (msg_ready !== 1'b0) begin
                    nfail++;
                    $display("FAIL R7 msg_ready while tag pending: got %b expected 0", msg_ready);
                end
            end
            if (prev_hold) begin
                nchk++;
                if (tag_valid !== 1'b1 || tag !== prev_tag) begin
                    nfail++;
                    $display("FAIL R7 tag not held: got %b/%h expected 1/%h", tag_valid, tag, prev_tag);
                end
            end
            // message bytes
            msg_valid = (bq.size() != 0) && go();
            msg_byte  = (bq.size() != 0) ? bq[0] : 8'h00;
            msg_last  = (lq.size() != 0) ? lq[0] : 1'b0;
            if (msg_valid && msg_ready) begin
                cur.push_back(bq.pop_front());
                if (lq.pop_front()) finish_message();
            end
            // key words, in element order with stalls (R4, R9)
            key_valid = go();
            key_word  = key_of(kidx);
            if (key_valid && key_ready) kidx++;
            // pad word
            pad_valid = go();
            pad_word  = pad_of(tag_idx);
            if (pad_valid && pad_ready) begin
                nchk++;
                if (exp_nel.size() == 0 || kidx != exp_nel[0]) begin
                    nfail++;
                    $display("FAIL R10 R3 key handshakes: got %0d expected %0d",
                             kidx, (exp_nel.size() != 0) ? exp_nel[0] : -1);
                end
            end
            // tag acceptance
            tag_ready = go();
            if (tag_valid && tag_ready) begin
                if (exp_tag.size() != 0) void'(exp_tag.pop_front());
                if (exp_nel.size() != 0) void'(exp_nel.pop_front());
                kidx = 0;
                tag_idx++;
                done_cnt++;
            end
            prev_hold = tag_valid && !tag_ready;
            prev_tag  = tag;
        end
    end

    task automatic wait_done(int n);
        while (done_cnt < n && cyc < LIMIT) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle state after reset
        nchk++;
        if (tag_valid !== 1'b0 || key_ready !== 1'b0 || pad_ready !== 1'b0 || msg_ready !== 1'b1) begin
            nfail++;
            $display("FAIL R1 reset state: got tv=%b kr=%b pr=%b mr=%b expected 0 0 0 1",
                     tag_valid, key_ready, pad_ready, msg_ready);
        end
        // boundary lengths around 32 and 64 bytes (R3, R10)
        load_msg(1, 1);
        load_msg(31, 2);
        load_msg(32, 3);
        load_msg(63, 4);
        load_msg(64, 5);
        load_msg(65, 6);
        run = 1'b1;
        wait_done(6);
        // stalls on all ports; repeated content checks the fresh start (R8, R9)
        stress = 1'b1;
        load_msg(100, 7);
        load_msg(1, 1);
        load_msg(64, 8);
        load_msg(33, 9);
        wait_done(10);
        if (cyc >= LIMIT) begin
            nfail++;
            $display("FAIL watchdog: got %0d tags expected 10", done_cnt);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

endmodule